// File: doc/BRIEF.md
# Sticky Interrupt Status Unit

This block gathers one-cycle event pulses and error conditions into a register of sticky status flags. A host reads that register, which clears it, and writes a per-bit mask that selects which flags may raise the interrupt line. Two of the flags summarise error conditions whose detailed cause lives in separate error-cause registers. These two flags are released only when the host has read both the status register and the matching cause register, and the error source has gone quiet.

A single output pin serves two purposes. A control bit picks whether the pin carries the interrupt or the left-channel zero-audio flag. The host reaches the status, mask, control and both cause registers through one small register port. The read data is combinational, and a read strobe acts at the clock edge.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status register, the mask register and the control bit are all 0, `irq` is 0, and `pin_out` follows `zero_left`.
- R2: Status bit k+2 is set by a pulse on `ev_pulse[k]`. Bit 2 is the transmit user-buffer-ready event. A set bit stays set until a status read clears it.
- R3: A read with `host_sel`=0 returns the status bits on `host_rdata` in that cycle. The read clears the event bits (bits 2 and up) at the clock edge.
- R4: An event pulse that arrives in the same cycle as a clearing status read leaves its bit set after that edge.
- R5: `irq` is high exactly when some status bit and its mask bit are both 1. A bit whose mask bit is 0 never raises `irq`.
- R6: A write with `host_sel`=1 loads the mask, and a write with `host_sel`=2 loads the control bit from `host_wdata[0]`. Both read back at the same addresses. Writes to the status address have no effect on the status register.
- R7: Status bit 0 summarises the converter error and status bit 1 summarises the receiver error. Each is set while its `*_err_active` input is high. Each clears only after a status read and a read of its cause register have both occurred while the bit was set, and the source is inactive. If both reads happened while the source was still active, the bit clears at the first edge at which the source is low.
- R8: A read with `host_sel`=3 returns `conv_err_cause`, and a read with `host_sel`=4 returns `rx_err_cause`.
- R9: When the control bit is 1, `pin_out` carries `irq`. When it is 0, `pin_out` carries `zero_left`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pulse | input | W-2 | Event pulses for status bits 2 and up |
| conv_err_active | input | 1 | Converter error condition present |
| rx_err_active | input | 1 | Receiver error condition present |
| conv_err_cause | input | W | Converter error cause register contents |
| rx_err_cause | input | W | Receiver error cause register contents |
| host_sel | input | 3 | Register select: 0 status, 1 mask, 2 control, 3 converter cause, 4 receiver cause |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | W | Write data |
| host_rdata | output | W | Read data for the selected register |
| zero_left | input | 1 | Left-channel zero-audio flag |
| irq | output | 1 | Masked interrupt |
| pin_out | output | 1 | Dual-function pin |

## Verification
The bench sends an event into the same cycle as a clearing read. A design that cleared unconditionally would lose that event and show a zero bit afterwards. It releases a summary error flag after only the status read, and separately while the source is still active. A design that ignored either read or the live source would drop the interrupt early. It also writes to the read-only status address, and switches the pin between its two functions while `irq` and `zero_left` differ. These cases catch a status register that takes writes and a pin mux that picks the wrong input.

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-3:0] ev_pulse,
  input  logic         conv_err_active,
  input  logic         rx_err_active,
  input  logic [W-1:0] conv_err_cause,
  input  logic [W-1:0] rx_err_cause,
  input  logic [2:0]   host_sel,
  input  logic         host_rd,
  input  logic         host_wr,
  input  logic [W-1:0] host_wdata,
  output logic [W-1:0] host_rdata,
  input  logic         zero_left,
  output logic         irq,
  output logic         pin_out
);
  localparam int NEV = W - 2;
  localparam logic [2:0] A_STAT = 3'd0;
  localparam logic [2:0] A_MASK = 3'd1;
  localparam logic [2:0] A_CTRL = 3'd2;
  localparam logic [2:0] A_CERR = 3'd3;
  localparam logic [2:0] A_RERR = 3'd4;

  logic [W-1:0]   status, mask;
  logic           ctrl;
  logic [1:0]     st_seen, er_seen, st_seen_n, er_seen_n, sum_n;
  logic [NEV-1:0] gen_n;

  wire       stat_rd = host_rd && (host_sel == A_STAT);
  wire [1:0] err_rd  = {host_rd && (host_sel == A_RERR), host_rd && (host_sel == A_CERR)};
  wire [1:0] err_act = {rx_err_active, conv_err_active};

  for (genvar i = 0; i < 2; i++) begin : g_sum
    assign st_seen_n[i] = st_seen[i] | (stat_rd   & status[i]);
    assign er_seen_n[i] = er_seen[i] | (err_rd[i] & status[i]);
    assign sum_n[i]     = err_act[i] | (status[i] & ~(st_seen_n[i] & er_seen_n[i]));
  end

  assign gen_n = ev_pulse | (status[W-1:2] & ~{NEV{stat_rd}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status  <= '0;
      mask    <= '0;
      ctrl    <= 1'b0;
      st_seen <= '0;
      er_seen <= '0;
    end else begin
      status  <= {gen_n, sum_n};
      st_seen <= st_seen_n & sum_n;
      er_seen <= er_seen_n & sum_n;
      if (host_wr && host_sel == A_MASK) mask <= host_wdata;
      if (host_wr && host_sel == A_CTRL) ctrl <= host_wdata[0];
    end
  end

  always_comb begin
    case (host_sel)
      A_STAT:  host_rdata = status;
      A_MASK:  host_rdata = mask;
      A_CTRL:  host_rdata = {{(W-1){1'b0}}, ctrl};
      A_CERR:  host_rdata = conv_err_cause;
      A_RERR:  host_rdata = rx_err_cause;
      default: host_rdata = '0;
    endcase
  end

  assign irq     = |(status & mask);
  assign pin_out = ctrl ? irq : zero_left;
endmodule

// File: rtl/irq_status_sva.sv
module irq_status_sva #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-3:0] ev_pulse,
  input logic         conv_err_active,
  input logic [2:0]   host_sel,
  input logic         host_rd,
  input logic [W-1:0] status,
  input logic [W-1:0] mask,
  input logic         ctrl,
  input logic         irq
);
  localparam logic [W-1:0] GM = ~{{(W-2){1'b0}}, 2'b11};
  wire stat_rd = host_rd && (host_sel == 3'd0);

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (status == '0 && mask == '0 && !ctrl));

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((status & $past(status) & GM) == ($past(status) & GM)));

  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && ev_pulse == '0) |=> ((status & GM) == '0));

  a_r4_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && ev_pulse != '0) |=> ((status[W-1:2] & $past(ev_pulse)) == $past(ev_pulse)));

  a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);

  a_r7_set_on_active: assert property (@(posedge clk) disable iff (!rst_n)
    conv_err_active |=> status[0]);

  a_r7_no_clear_while_active: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> !$past(conv_err_active));
endmodule

bind irq_status_unit irq_status_sva #(.W(W)) u_sva (
  .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .conv_err_active(conv_err_active),
  .host_sel(host_sel), .host_rd(host_rd), .status(status), .mask(mask),
  .ctrl(ctrl), .irq(irq)
);

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
  localparam int W = 8;
  localparam int N = 9;
  localparam logic [5:0] V_EV  [N] = '{6'h01, 6'h04, 6'h00, 6'h20, 6'h02, 6'h00, 6'h10, 6'h10, 6'h00};
  localparam logic       V_RD  [N] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [7:0] V_ST  [N] = '{8'h04, 8'h14, 8'h00, 8'h80, 8'h08, 8'h00, 8'h40, 8'h40, 8'h00};
  localparam logic       V_IRQ [N] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};

  logic clk = 0, rst_n = 0;
  logic [W-3:0] ev_pulse = '0;
  logic conv_err_active = 0, rx_err_active = 0;
  logic [W-1:0] conv_err_cause = 8'hA5, rx_err_cause = 8'h3C;
  logic [2:0] host_sel = '0;
  logic host_rd = 0, host_wr = 0;
  logic [W-1:0] host_wdata = '0, host_rdata;
  logic zero_left = 0, irq, pin_out;
  int total = 0, bad = 0;
  logic [7:0] d, prev;

  always #5 clk = ~clk;

  irq_status_unit #(.W(W)) dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #2; endtask

  task automatic rd(input logic [2:0] sel, output logic [7:0] data);
    host_sel = sel; host_rd = 1; #1 data = host_rdata; tick(); host_rd = 0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] data);
    host_sel = sel; host_wdata = data; host_wr = 1; tick(); host_wr = 0;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1; tick();
    // R1 reset state
    check("R1 irq", irq, 0);
    zero_left = 1; #1 check("R1 pin zero", pin_out, 1);
    zero_left = 0; #1 check("R1 pin zero low", pin_out, 0);
    rd(3'd1, d); check("R1 mask", d, 8'h00);
    rd(3'd2, d); check("R1 ctrl", d, 8'h00);
    rd(3'd0, d); check("R1 status", d, 8'h00);

    // R6 register access
    wr(3'd1, 8'hF0); rd(3'd1, d); check("R6 mask readback", d, 8'hF0);
    wr(3'd0, 8'hFF); rd(3'd0, d); check("R6 status write ignored", d, 8'h00);

    // R2 R3 R4 R5 vector table
    prev = 8'h00;
    for (int i = 0; i < N; i++) begin
      ev_pulse = V_EV[i]; host_sel = 3'd0; host_rd = V_RD[i];
      #1 if (V_RD[i]) check("R3 status read data", host_rdata, prev);
      tick();
      ev_pulse = '0; host_rd = 0;
      check($sformatf("R2/R4 irq step %0d", i), irq, V_IRQ[i]);
      if (V_RD[i + 1 < N ? i + 1 : i] == 1'b0 || i == N - 1) begin end
      prev = V_ST[i];
    end
    rd(3'd0, d); check("R3 cleared after table", d, 8'h00);

    // R4 explicit: event with read
    ev_pulse = 6'h08; host_sel = 3'd0; host_rd = 1; tick(); ev_pulse = '0; host_rd = 0;
    rd(3'd0, d); check("R4 same-cycle event kept", d, 8'h20);

    // R5 masking
    wr(3'd1, 8'h00);
    ev_pulse = 6'h3F; tick(); ev_pulse = '0;
    check("R5 all masked", irq, 0);
    wr(3'd1, 8'h08); check("R5 bit3 enabled", irq, 1);
    rd(3'd0, d); check("R5 status all events", d, 8'hFC);
    check("R5 irq after clear", irq, 0);

    // R9 pin select
    wr(3'd2, 8'h01); rd(3'd2, d); check("R6 ctrl readback", d, 8'h01);
    zero_left = 1; #1 check("R9 pin irq low", pin_out, 0);
    ev_pulse = 6'h02; tick(); ev_pulse = '0;
    zero_left = 0; #1 check("R9 pin irq high", pin_out, 1);
    wr(3'd2, 8'h00); #1 check("R9 pin back to zero flag", pin_out, 0);
    rd(3'd0, d);

    // R7 summary bit, pulse source
    wr(3'd1, 8'h03);
    conv_err_active = 1; tick(); conv_err_active = 0;
    check("R7 conv set", irq, 1);
    rd(3'd0, d); check("R7 status shows conv", d, 8'h01);
    check("R7 held after status read only", irq, 1);
    rd(3'd3, d); check("R8 conv cause", d, 8'hA5);
    check("R7 conv cleared after both reads", irq, 0);

    // R7 cause read first, then status
    conv_err_active = 1; tick(); conv_err_active = 0;
    rd(3'd3, d); check("R7 held after cause read only", irq, 1);
    rd(3'd0, d); check("R7 cleared cause-then-status", irq, 0);

    // R7 held source
    rx_err_active = 1; tick();
    rd(3'd0, d); check("R7 status shows rx", d, 8'h02);
    rd(3'd4, d); check("R8 rx cause", d, 8'h3C);
    check("R7 held while active", irq, 1);
    tick(); check("R7 still held", irq, 1);
    rx_err_active = 0; tick();
    check("R7 cleared when source drops", irq, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule